// File: doc/BRIEF.md
# Cascadable Dual 8-bit Pulse Generator

This block holds two down-counting pulse channels that share one control register. A 2-bit mode field decides how the two 8-bit counters are wired. They can run as two separate pulse channels. The lower counter can act as a prescaler that paces the upper channel. The two counters can also be joined into one 16-bit channel. Each channel has two reload values, one for the low phase of its output and one for the high phase. When the counter passes zero it loads the value for the next phase and its output toggles. Counting advances only on cycles where the single `tick_i` input is high.

Software drives the block through a small synchronous register bus. Read data appears one cycle after the read strobe. An underflow flag follows whichever counter width is active, and an interrupt line is raised from it when interrupts are enabled. The flag is cleared by writing 0; writing 1 leaves it alone. A read marked as part of a read-modify-write always returns the flag as 1, so a bit operation on another control field cannot clear the flag by accident.

Top module: `dual_pulse_gen`

## Requirements
- R1: After reset, the control register reads 0x00, both pulse outputs are low and `irq_o` is low.
- R2: Register map and readback. Writes take effect at the clock edge on which `wr_en_i` is high. `rd_data_o` holds the addressed register one cycle after `rd_en_i`. The addresses are:
  - 0: control.
  - 1: channel 0 low width.
  - 2: channel 0 high width.
  - 3: channel 1 low width.
  - 4: channel 1 high width.
- R3: Control register bit layout:
  - bit 0: run channel 0.
  - bit 1: run channel 1.
  - bit 2: interrupt enable.
  - bit 3: underflow flag.
  - bits 5:4: mode. 00 = split, 01 = prescaled, 10 = reserved, 11 = wide.
  - bits 7:6: read as 0.
- R4: In split mode each channel runs on its own. After its run bit is set, the output is low for (low width + 1) ticks and then high for (high width + 1) ticks, and this alternation repeats.
- R5: In prescaled mode, when channel 0 has equal low and high widths P, each phase of `pulse1_o` lasts (channel 1 width + 1) × (P + 1) ticks. `pulse0_o` stays low in this mode.
- R6: In wide mode the pair runs while run bit 1 is set. Each phase of `pulse1_o` lasts ({ch1 width, ch0 width} + 1) ticks, and `pulse0_o` stays low. The upper counter moves only when the lower counter wraps.
- R7: In split and prescaled modes, the underflow flag is set only when the channel 1 counter wraps past zero. Channel 0 alone never sets it.
- R8: In wide mode, the underflow flag is set when the combined 16-bit counter wraps past zero.
- R9: A control write with bit 3 = 0 clears the flag. A control write with bit 3 = 1 leaves the flag unchanged.
- R10: A control read with `rmw_i` high returns bit 3 as 1. A plain read returns the true flag value.
- R11: `irq_o` is high exactly while the interrupt enable bit and the underflow flag are both 1.
- R12: In the reserved mode the counters hold, the pulse outputs do not change, and the flag is not set.
- R13: Clearing a run bit stops that channel, and its output is low from the second cycle after the write on. While `tick_i` is low, no counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable; counters advance only on cycles where it is high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| rmw_i | input | 1 | Marks a read as part of a read-modify-write |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data, valid one cycle after `rd_en_i` |
| pulse0_o | output | 1 | Channel 0 pulse output |
| pulse1_o | output | 1 | Channel 1 pulse output |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the reserved mode entered while channel 1 is mid-count, and the wide-mode underflow. The wide-mode underflow needs the lower counter to wrap through 0xFF into an upper decrement before the combined wrap occurs.

- Reserved mode: the bench first runs channel 1 in split mode. It then uses a single control write that both clears the flag and selects the reserved code. The output and the flag are then watched to confirm they stay frozen.
- Wide mode: the bench uses an upper width of 1, so the phase spans more than 256 ticks. A full phase is timed, and the flag is read afterwards.
- Random channel widths and prescale factors are mixed with these directed cases.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_PRESC = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_WIDE  = 2'b11
  } mode_e;

  localparam int unsigned RUN0_B = 0;
  localparam int unsigned RUN1_B = 1;
  localparam int unsigned IEN_B  = 2;
  localparam int unsigned FLAG_B = 3;
  localparam int unsigned MODE_L = 4;
  localparam int unsigned MODE_H = 5;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_WID0 = 1;
endpackage

// File: rtl/dpg_regs.sv
module dpg_regs
  import dpg_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  rmw,
  input  logic [AW-1:0]         addr,
  input  logic [W-1:0]          wr_data,
  input  logic                  flag_set,
  output logic [NCH-1:0]        run,
  output logic                  ien,
  output logic                  flag,
  output logic [1:0]            mode,
  output logic [NCH-1:0][W-1:0] wid_lo,
  output logic [NCH-1:0][W-1:0] wid_hi,
  output logic [W-1:0]          rd_data
);
  logic          ctrl_wr;
  logic [W-1:0]  ctrl_rd;

  assign ctrl_wr = wr_en && (addr == AW'(ADDR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      ien  <= 1'b0;
      mode <= 2'b00;
      flag <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run[0] <= wr_data[RUN0_B];
        run[1] <= wr_data[RUN1_B];
        ien    <= wr_data[IEN_B];
        mode   <= wr_data[MODE_H:MODE_L];
      end
      if (flag_set)
        flag <= 1'b1;
      else if (ctrl_wr && !wr_data[FLAG_B])
        flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wid_lo <= '0;
      wid_hi <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(ADDR_WID0 + 2*i))
          wid_lo[i] <= wr_data;
        if (addr == AW'(ADDR_WID0 + 2*i + 1))
          wid_hi[i] <= wr_data;
      end
    end
  end

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[RUN0_B]        = run[0];
    ctrl_rd[RUN1_B]        = run[1];
    ctrl_rd[IEN_B]         = ien;
    ctrl_rd[FLAG_B]        = flag | rmw;
    ctrl_rd[MODE_H:MODE_L] = mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (addr == AW'(ADDR_CTRL))
        rd_data <= ctrl_rd;
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(ADDR_WID0 + 2*i))
          rd_data <= wid_lo[i];
        if (addr == AW'(ADDR_WID0 + 2*i + 1))
          rd_data <= wid_hi[i];
      end
    end
  end
endmodule

// File: rtl/dpg_link.sv
module dpg_link
  import dpg_pkg::*;
(
  input  logic [1:0]     mode,
  input  logic           tick,
  input  logic [NCH-1:0] run,
  input  logic [NCH-1:0] zero,
  output logic [NCH-1:0] run_ch,
  output logic [NCH-1:0] ce,
  output logic [NCH-1:0] reload,
  output logic [NCH-1:0] oen
);
  always_comb begin
    run_ch = run;
    ce     = '0;
    reload = '0;
    oen    = 2'b11;
    case (mode_e'(mode))
      MODE_SPLIT: begin
        ce     = {tick, tick};
        reload = zero;
      end
      MODE_PRESC: begin
        ce[0]  = tick;
        ce[1]  = tick && zero[0] && run[0];
        reload = zero;
        oen    = 2'b10;
      end
      MODE_WIDE: begin
        run_ch = {run[1], run[1]};
        ce[0]  = tick;
        ce[1]  = tick && zero[0];
        reload = {zero[0] && zero[1], zero[0] && zero[1]};
        oen    = 2'b10;
      end
      default: begin
        ce     = '0;
        reload = '0;
      end
    endcase
  end
endmodule

// File: rtl/dpg_chan.sv
module dpg_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         ce,
  input  logic         reload,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] cnt,
  output logic         zero,
  output logic         phase
);
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= lo;
      phase <= 1'b0;
    end else if (ce) begin
      if (reload) begin
        phase <= ~phase;
        cnt   <= phase ? lo : hi;
      end else begin
        cnt <= cnt - W'(1);
      end
    end
  end
endmodule

// File: rtl/dual_pulse_gen.sv
module dual_pulse_gen
  import dpg_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          rmw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic [W-1:0]  rd_data_o,
  output logic          pulse0_o,
  output logic          pulse1_o,
  output logic          irq_o
);
  logic [NCH-1:0]        run_q;
  logic                  ien_q;
  logic                  flag_q;
  logic [1:0]            mode_q;
  logic [NCH-1:0][W-1:0] wid_lo;
  logic [NCH-1:0][W-1:0] wid_hi;
  logic [NCH-1:0][W-1:0] cnt;
  logic [NCH-1:0]        zero;
  logic [NCH-1:0]        phase;
  logic [NCH-1:0]        run_ch;
  logic [NCH-1:0]        ce;
  logic [NCH-1:0]        reload;
  logic [NCH-1:0]        oen;
  logic                  flag_set;

  dpg_regs #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i),
    .rd_en    (rd_en_i),
    .rmw      (rmw_i),
    .addr     (addr_i),
    .wr_data  (wr_data_i),
    .flag_set (flag_set),
    .run      (run_q),
    .ien      (ien_q),
    .flag     (flag_q),
    .mode     (mode_q),
    .wid_lo   (wid_lo),
    .wid_hi   (wid_hi),
    .rd_data  (rd_data_o)
  );

  dpg_link u_link (
    .mode   (mode_q),
    .tick   (tick_i),
    .run    (run_q),
    .zero   (zero),
    .run_ch (run_ch),
    .ce     (ce),
    .reload (reload),
    .oen    (oen)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dpg_chan #(.W(W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .run    (run_ch[g]),
      .ce     (ce[g]),
      .reload (reload[g]),
      .lo     (wid_lo[g]),
      .hi     (wid_hi[g]),
      .cnt    (cnt[g]),
      .zero   (zero[g]),
      .phase  (phase[g])
    );
  end

  assign flag_set = run_ch[1] && ce[1] && reload[1];
  assign pulse0_o = phase[0] && oen[0];
  assign pulse1_o = phase[1] && oen[1];
  assign irq_o    = ien_q && flag_q;
endmodule

// File: rtl/dpg_chk.sv
module dpg_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rmw,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  rd_data,
  input logic [1:0]    mode,
  input logic [1:0]    run,
  input logic          flag,
  input logic [W-1:0]  cnt0,
  input logic [W-1:0]  cnt1,
  input logic          pulse1
);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0 && !wr_data[3] && cnt1 != '0) |=> !flag);

  // R10
  rmw_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rmw && addr == '0) |=> rd_data[3]);

  // R12
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && run == 2'b11 && !wr_en) |=> ($stable(cnt0) && $stable(cnt1)));

  // R6
  wide_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && run[1] && !wr_en && cnt0 != '0) |=> $stable(cnt1));

  // R13
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run[1] |=> !pulse1);

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(cnt1) == '0));
endmodule

bind dual_pulse_gen dpg_chk #(.W(W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en_i),
  .rd_en   (rd_en_i),
  .rmw     (rmw_i),
  .addr    (addr_i),
  .wr_data (wr_data_i),
  .rd_data (rd_data_o),
  .mode    (mode_q),
  .run     (run_q),
  .flag    (flag_q),
  .cnt0    (cnt[0]),
  .cnt1    (cnt[1]),
  .pulse1  (pulse1_o)
);

// File: tb/dual_pulse_gen_tb.sv
module dual_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       rmw = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       p0, p1, irq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  dual_pulse_gen u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rmw_i(rmw), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .pulse0_o(p0), .pulse1_o(p1), .irq_o(irq)
  );

  function automatic int exp_split(input int w);
    return w + 1;
  endfunction
  function automatic int exp_presc(input int w1, input int p);
    return (w1 + 1) * (p + 1);
  endfunction
  function automatic int exp_wide(input int up, input int low);
    return up * 256 + low + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input bit m, output int d);
    @(negedge clk);
    rd_en = 1'b1; rmw = m; addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0; rmw = 1'b0;
    d = int'(rdata);
  endtask

  function automatic logic pin(input int sel);
    return (sel == 0) ? p0 : p1;
  endfunction

  task automatic measure(input int sel, output int hi, output int lo);
    logic prev, cur;
    int guard;
    hi = 0; lo = 0; guard = 0;
    prev = pin(sel);
    forever begin
      @(negedge clk);
      cur = pin(sel);
      guard++;
      if ((prev == 1'b0 && cur == 1'b1) || guard > 3000) break;
      prev = cur;
    end
    hi = 1;
    while (pin(sel) == 1'b1 && hi < 3000) begin @(negedge clk); if (pin(sel)) hi++; end
    lo = 1;
    while (pin(sel) == 1'b0 && lo < 3000) begin @(negedge clk); if (!pin(sel)) lo++; end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int d, hi, lo, v, saved, seen0;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(0, 0, d);
    chk("R1 ctrl", d, 0);
    chk("R1 pulse0", int'(p0), 0);
    chk("R1 pulse1", int'(p1), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 width readback at addresses 1..4
    for (int a = 1; a <= 4; a++) begin
      v = int'($urandom_range(255));
      wr(a, v);
      rd(a, 0, d);
      chk("R2 width readback", d, v);
    end
    // R3 control field layout (run 00, ien 1, mode 11)
    wr(0, 8'h34);
    rd(0, 0, d);
    chk("R3 ctrl fields", d, 8'h34);
    wr(0, 8'h00);

    // R4 split mode, directed and random widths
    wr(1, 3); wr(2, 5);
    wr(0, 8'h01);
    measure(0, hi, lo);
    chk("R4 high phase", hi, exp_split(5));
    chk("R4 low phase", lo, exp_split(3));
    wr(0, 8'h00);
    for (int k = 0; k < 5; k++) begin
      int l0, h0, l1, h1, hi1, lo1;
      l0 = int'($urandom_range(15)); h0 = int'($urandom_range(15));
      l1 = int'($urandom_range(15)); h1 = int'($urandom_range(15));
      wr(1, l0); wr(2, h0); wr(3, l1); wr(4, h1);
      wr(0, 8'h03);
      measure(0, hi, lo);
      measure(1, hi1, lo1);
      chk("R4 rand ch0 high", hi, exp_split(h0));
      chk("R4 rand ch0 low", lo, exp_split(l0));
      chk("R4 rand ch1 high", hi1, exp_split(h1));
      chk("R4 rand ch1 low", lo1, exp_split(l1));
      wr(0, 8'h00);
    end

    // R13 tick low freezes counting
    wr(1, 2); wr(2, 2);
    wr(0, 8'h01);
    wait_cyc(4);
    tick = 1'b0;
    saved = int'(p0);
    seen0 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (int'(p0) != saved) seen0 = 1;
    end
    tick = 1'b1;
    chk("R13 tick low holds output", seen0, 0);

    // R7 channel 0 alone never sets the flag in split mode
    wr(0, 8'h01);
    wait_cyc(60);
    rd(0, 0, d);
    chk("R7 flag after ch0 only", (d >> 3) & 1, 0);
    wr(3, 3); wr(4, 3);
    wr(0, 8'h03);
    wait_cyc(20);
    rd(0, 0, d);
    chk("R7 flag after ch1 wrap", d, 8'h0B);
    chk("R11 irq with enable off", int'(irq), 0);
    wr(0, 8'h0F);
    chk("R11 irq with enable on", int'(irq), 1);

    // R13 stop forces outputs low; R9 write 1 keeps flag
    wr(0, 8'h0C);
    @(negedge clk);
    chk("R13 pulse0 low after stop", int'(p0), 0);
    chk("R13 pulse1 low after stop", int'(p1), 0);
    chk("R9 write 1 keeps flag", int'(irq), 1);
    wr(0, 8'h04);
    chk("R9 write 0 clears flag irq", int'(irq), 0);
    rd(0, 0, d);
    chk("R9 ctrl after clear", d, 8'h04);
    // R10 read-modify-write read
    rd(0, 1, d);
    chk("R10 rmw read", d, 8'h0C);
    rd(0, 0, d);
    chk("R10 plain read", d, 8'h04);
    wr(0, 8'h00);

    // R5 prescaled mode
    for (int k = 0; k < 5; k++) begin
      int p, w1, l1, bad0;
      p  = int'($urandom_range(5));
      w1 = int'($urandom_range(7));
      l1 = int'($urandom_range(7));
      wr(1, p); wr(2, p); wr(3, l1); wr(4, w1);
      wr(0, 8'h13);
      measure(1, hi, lo);
      chk("R5 presc high", hi, exp_presc(w1, p));
      chk("R5 presc low", lo, exp_presc(l1, p));
      bad0 = 0;
      for (int j = 0; j < 20; j++) begin @(negedge clk); if (p0) bad0 = 1; end
      chk("R5 pulse0 held low", bad0, 0);
      rd(0, 0, d);
      chk("R7 presc flag set", (d >> 3) & 1, 1);
      wr(0, 8'h00);
    end

    // R6 and R8 wide mode
    wr(1, 5); wr(2, 2); wr(3, 0); wr(4, 1);
    wr(0, 8'h32);
    measure(1, hi, lo);
    chk("R6 wide high", hi, exp_wide(1, 2));
    chk("R6 wide low", lo, exp_wide(0, 5));
    chk("R6 pulse0 low", int'(p0), 0);
    rd(0, 0, d);
    chk("R8 wide flag", (d >> 3) & 1, 1);
    wr(0, 8'h00);

    // R12 reserved mode freezes a running channel
    wr(3, 4); wr(4, 6);
    wr(0, 8'h02);
    wait_cyc(9);
    wr(0, 8'h22);
    saved = int'(p1);
    seen0 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (int'(p1) != saved) seen0 = 1;
    end
    chk("R12 pulse1 frozen", seen0, 0);
    rd(0, 0, d);
    chk("R12 no flag in reserved", d, 8'h22);
    wr(0, 8'h02);
    wait_cyc(30);
    rd(0, 0, d);
    chk("R12 counting resumes", (d >> 3) & 1, 1);
    wr(0, 8'h00);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule